// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of one hardware thread. It is organised as a ring of overlapping register windows that acts as a call stack in hardware. Software names 32 architectural registers with a 5-bit number. Eight of them are globals and stay the same in every window. The other 24 are seen through the current window pointer. Because the out registers of one window are the same storage as the in registers of the next window, a call or a return passes arguments and results without copying any data.

A `save_req` strobe is issued on a call and moves the pointer one window up. A `restore_req` strobe is issued on a return and moves it one window back. A small state machine counts how many windows are nested. It has three states:

- **BASE**: no window is nested.
- **NESTED**: some windows are nested and more room remains.
- **FULL**: the deepest legal window is in use.

The transitions between them are:

- **BASE→NESTED**: on a save.
- **NESTED→NESTED**: on a save that does not yet reach the limit, or a restore that leaves more than one window nested.
- **NESTED→FULL**: on a save that reaches the limit.
- **NESTED→BASE**: on a restore from depth one.
- **FULL→NESTED**: on a restore.
- **FULL→FULL**: on a save, which raises the overflow trap.
- **BASE→BASE**: on a restore, which raises the underflow trap.

One window is never entered, because its out registers would overwrite the in registers of the oldest window. With 8 windows, the deepest legal nesting is therefore 6. Spill and fill handlers outside this block react to the traps.

Top module: `windowed_regfile`

## Requirements
- R1: After reset the window pointer is 0, both trap outputs are 0, and every architectural register reads 0.
- R2: Architectural register 0 always reads 0, and a write to it has no effect.
- R3: Registers 1–7 are globals. A value written to one of them reads back the same in every window.
- R4: Registers 8–15 are out k = reg-8, and registers 24–31 are in k = reg-24. After a save without a trap, the pointer rises by one modulo 8, and in k reads the value that out k held before the save.
- R5: After a restore without a trap, the pointer falls by one modulo 8. Out k then reads the value the callee left in its in k, and the caller's own out values are intact.
- R6: Registers 16–23 are locals private to each window. A local written in one window does not appear in the next window, and it is intact again after returning to the first window.
- R7: A save at nesting depth 6 leaves the pointer unchanged. It raises `overflow_trap` for exactly the one cycle after the request.
- R8: A restore at nesting depth 0 leaves the pointer unchanged. It raises `underflow_trap` for exactly the one cycle after the request.
- R9: When save and restore are requested in the same cycle, neither takes effect and no trap is raised.
- R10: A read of the register being written in the same cycle returns the new write data.
- R11: A write in the same cycle as a save or restore is addressed through the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Architectural register number, read port A |
| rd_data_a | output | 32 | Read data, port A (combinational, with bypass) |
| rd_addr_b | input | 5 | Architectural register number, read port B |
| rd_data_b | output | 32 | Read data, port B (combinational, with bypass) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number for the write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Call strobe: move to the next window |
| restore_req | input | 1 | Return strobe: move to the previous window |
| cur_window | output | 3 | Current window pointer |
| overflow_trap | output | 1 | One-cycle pulse: a save was refused |
| underflow_trap | output | 1 | One-cycle pulse: a restore was refused |

## Verification
A directed call/return sequence writes distinct values into out, local and global registers. It then reads them through the in, local and out names of the neighbouring windows. This separates the correct overlap from an off-by-one window or a swapped in/out mapping, and it shows whether locals leak between windows.

A run of seven saves followed by restores at the base checks the depth limit and both traps. Same-cycle write/read pairs and writes issued together with a strobe separate the bypass and the use of the pre-move window from a design that reads stale data or writes through the new window.

A long pseudo-random stream of reads, writes and strobes is compared every clock with a behavioural model. That model keys storage by window and register role, which exposes pointer wrap-around errors.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    // Architectural register number width and register group size
    localparam int AW  = 5;
    localparam int GRP = 8;

    typedef enum logic [1:0] {
        ST_BASE,
        ST_NESTED,
        ST_FULL
    } win_state_e;

    typedef enum logic [1:0] {
        RG_GLOBAL = 2'd0,
        RG_OUT    = 2'd1,
        RG_LOCAL  = 2'd2,
        RG_IN     = 2'd3
    } reg_group_e;
endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int DW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    output logic [CW-1:0] cwp,
    output logic          ovf_trap,
    output logic          unf_trap
);
    localparam logic [DW-1:0] MAXD = DW'(NWIN - 2);
    localparam logic [CW-1:0] TOPW = CW'(NWIN - 1);

    win_state_e    state, state_nxt;
    logic [DW-1:0] depth;
    logic          go_up, go_dn, set_ovf, set_unf;
    logic          do_save, do_rest;

    assign do_save = save_req & ~restore_req;
    assign do_rest = restore_req & ~save_req;

    // Next state and actions
    always_comb begin
        state_nxt = state;
        go_up     = 1'b0;
        go_dn     = 1'b0;
        set_ovf   = 1'b0;
        set_unf   = 1'b0;
        unique case (state)
            ST_BASE: begin
                if (do_save) begin
                    go_up     = 1'b1;
                    state_nxt = (MAXD == DW'(1)) ? ST_FULL : ST_NESTED;
                end else if (do_rest) begin
                    set_unf = 1'b1;
                end
            end
            ST_NESTED: begin
                if (do_save) begin
                    go_up     = 1'b1;
                    state_nxt = (depth == MAXD - DW'(1)) ? ST_FULL : ST_NESTED;
                end else if (do_rest) begin
                    go_dn     = 1'b1;
                    state_nxt = (depth == DW'(1)) ? ST_BASE : ST_NESTED;
                end
            end
            ST_FULL: begin
                if (do_save) begin
                    set_ovf = 1'b1;
                end else if (do_rest) begin
                    go_dn     = 1'b1;
                    state_nxt = (MAXD == DW'(1)) ? ST_BASE : ST_NESTED;
                end
            end
            default: state_nxt = ST_BASE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BASE;
        else        state <= state_nxt;
    end

    // Outputs: pointer, depth and trap pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp      <= '0;
            depth    <= '0;
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
        end else begin
            ovf_trap <= set_ovf;
            unf_trap <= set_unf;
            if (go_up) begin
                cwp   <= (cwp == TOPW) ? '0 : cwp + CW'(1);
                depth <= depth + DW'(1);
            end else if (go_dn) begin
                cwp   <= (cwp == '0) ? TOPW : cwp - CW'(1);
                depth <= depth - DW'(1);
            end
        end
    end
endmodule

// File: rtl/wrf_xlate.sv
module wrf_xlate
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW    = $clog2(NWIN),
    localparam int NPHYS = GRP + NWIN * 2 * GRP,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic [CW-1:0] cwp,
    input  logic [AW-1:0] arch,
    output logic [PW-1:0] phys
);
    int cur_w, nxt_w, off;

    always_comb begin
        cur_w = int'(cwp);
        nxt_w = (cur_w == NWIN - 1) ? 0 : cur_w + 1;
        off   = int'(arch[2:0]);
        unique case (reg_group_e'(arch[4:3]))
            RG_GLOBAL: phys = PW'(off);
            RG_OUT:    phys = PW'(GRP + nxt_w * 2 * GRP + GRP + off);
            RG_LOCAL:  phys = PW'(GRP + cur_w * 2 * GRP + off);
            RG_IN:     phys = PW'(GRP + cur_w * 2 * GRP + GRP + off);
            default:   phys = '0;
        endcase
    end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 136,
    parameter int NRD    = 2,
    localparam int PW = $clog2(NPHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_idx  [NRD],
    output logic [DATA_W-1:0] rd_data [NRD]
);
    logic [DATA_W-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (wr_en && wr_idx != '0) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read ports with same-cycle write bypass; entry 0 is the zero register
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == '0)
                rd_data[p] = '0;
            else if (wr_en && wr_idx == rd_idx[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_idx[p]];
        end
    end
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
    import wrf_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int DATA_W = 32,
    localparam int CW    = $clog2(NWIN),
    localparam int NPHYS = GRP + NWIN * 2 * GRP,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    output logic [CW-1:0]     cur_window,
    output logic              overflow_trap,
    output logic              underflow_trap
);
    localparam int NPORT = 3; // read A, read B, write

    logic [AW-1:0]     arch_sel [NPORT];
    logic [PW-1:0]     phys_sel [NPORT];
    logic [PW-1:0]     rd_idx   [2];
    logic [DATA_W-1:0] rd_val   [2];

    assign arch_sel[0] = rd_addr_a;
    assign arch_sel[1] = rd_addr_b;
    assign arch_sel[2] = wr_addr;

    wrf_ctrl #(.NWIN(NWIN)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cwp         (cur_window),
        .ovf_trap    (overflow_trap),
        .unf_trap    (underflow_trap)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        wrf_xlate #(.NWIN(NWIN)) i_xlate (
            .cwp  (cur_window),
            .arch (arch_sel[p]),
            .phys (phys_sel[p])
        );
    end

    assign rd_idx[0] = phys_sel[0];
    assign rd_idx[1] = phys_sel[1];

    wrf_store #(.DATA_W(DATA_W), .NPHYS(NPHYS), .NRD(2)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (phys_sel[2]),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_val)
    );

    assign rd_data_a = rd_val[0];
    assign rd_data_b = rd_val[1];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int NWIN   = 8,
    parameter int DATA_W = 32,
    localparam int CW = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              save_req,
    input logic              restore_req,
    input logic [CW-1:0]     cur_window,
    input logic              overflow_trap,
    input logic              underflow_trap,
    input logic [4:0]        rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a
);
    logic          armed;
    logic [CW-1:0] win_inc, win_dec;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign win_inc = (cur_window == CW'(NWIN - 1)) ? '0 : cur_window + CW'(1);
    assign win_dec = (cur_window == '0) ? CW'(NWIN - 1) : cur_window - CW'(1);

    assert_r0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_a == 5'd0 |-> rd_data_a == '0);

    assert_save_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(save_req && !restore_req) && !overflow_trap
        |-> cur_window == $past(win_inc));

    assert_restore_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(restore_req && !save_req) && !underflow_trap
        |-> cur_window == $past(win_dec));

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && overflow_trap |-> $past(save_req && !restore_req) && $stable(cur_window));

    assert_unf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && underflow_trap |-> $past(restore_req && !save_req) && $stable(cur_window));

    assert_no_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(save_req && restore_req)
        |-> $stable(cur_window) && !overflow_trap && !underflow_trap);
endmodule

bind windowed_regfile wrf_checker #(.NWIN(NWIN), .DATA_W(DATA_W)) i_wrf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .save_req       (save_req),
    .restore_req    (restore_req),
    .cur_window     (cur_window),
    .overflow_trap  (overflow_trap),
    .underflow_trap (underflow_trap),
    .rd_addr_a      (rd_addr_a),
    .rd_data_a      (rd_data_a)
);

// File: tb/test_windowed_regfile.sv
`timescale 1ns/1ps
module test_windowed_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [2:0]  cur_window;
    logic        overflow_trap, underflow_trap;

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural reference state
    logic [31:0] ref_mem [int];
    int m_cwp = 0;
    int m_depth = 0;
    logic m_ovf = 1'b0, m_unf = 1'b0;

    always #2.5 clk = ~clk;

    windowed_regfile i_windowed_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .cur_window(cur_window),
        .overflow_trap(overflow_trap), .underflow_trap(underflow_trap)
    );

    // Storage key by window role: out k of window w is in k of window w+1
    function automatic int key_of(input int w, input int r);
        if (r < 8)  return 1000 + r;
        if (r < 16) return ((w + 1) % 8) * 100 + 50 + (r - 8);
        if (r < 24) return w * 100 + (r - 16);
        return w * 100 + 50 + (r - 24);
    endfunction

    function automatic logic [31:0] expect_rd(input int r);
        if (r == 0) return 32'h0;
        if (wr_en && wr_addr != 0 && key_of(m_cwp, int'(wr_addr)) == key_of(m_cwp, r))
            return wr_data;
        if (ref_mem.exists(key_of(m_cwp, r))) return ref_mem[key_of(m_cwp, r)];
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive, check reads before the edge, update model, check registers after
    task automatic step(input logic we, input int wa, input logic [31:0] wd,
                        input int ra, input int rb, input logic sv, input logic rs,
                        input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
        save_req = sv; restore_req = rs;
        #0.5;
        check({tag, " read A"}, rd_data_a, expect_rd(ra));
        check({tag, " read B"}, rd_data_b, expect_rd(rb));
        @(posedge clk);
        if (we && wa != 0) ref_mem[key_of(m_cwp, wa)] = wd;
        m_ovf = 1'b0; m_unf = 1'b0;
        if (sv && !rs) begin
            if (m_depth == 6) m_ovf = 1'b1;
            else begin m_cwp = (m_cwp + 1) % 8; m_depth++; end
        end else if (rs && !sv) begin
            if (m_depth == 0) m_unf = 1'b1;
            else begin m_cwp = (m_cwp + 7) % 8; m_depth--; end
        end
        #0.5;
        check({tag, " window"}, 32'(cur_window), 32'(m_cwp));
        check({tag, " overflow_trap"}, 32'(overflow_trap), 32'(m_ovf));
        check({tag, " underflow_trap"}, 32'(underflow_trap), 32'(m_unf));
        wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0;
    endtask

    task automatic rd(input int ra, input int rb, input string tag);
        step(1'b0, 0, 32'h0, ra, rb, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int r = 0; r < 32; r++) rd(r, 31 - r, "R1");
        // R2: writes to register 0 ignored
        step(1'b1, 0, 32'hDEAD_0000, 0, 0, 1'b0, 1'b0, "R2");
        rd(0, 0, "R2");
        // R10: same-cycle bypass
        step(1'b1, 20, 32'h1111_2020, 20, 20, 1'b0, 1'b0, "R10");
        // Caller setup: out3, local2, global5
        step(1'b1, 11, 32'hA1A1_0003, 0, 0, 1'b0, 1'b0, "R4");
        step(1'b1, 18, 32'h10CA_0000, 0, 0, 1'b0, 1'b0, "R6");
        step(1'b1, 5,  32'h6106_0005, 0, 0, 1'b0, 1'b0, "R3");
        // R11: write out4 in the save cycle goes to the caller's window
        step(1'b1, 12, 32'hB4B4_0004, 11, 12, 1'b1, 1'b0, "R11");
        rd(27, 28, "R4");    // in3, in4 of callee
        rd(18, 5, "R6_R3");  // callee local2 empty, global5 visible
        step(1'b1, 26, 32'hC2C2_0002, 0, 0, 1'b0, 1'b0, "R5");
        step(1'b1, 18, 32'h10CA_0001, 0, 0, 1'b0, 1'b0, "R6");
        step(1'b0, 0, 32'h0, 0, 0, 1'b0, 1'b1, "R5");
        rd(10, 11, "R5");    // out2 = callee result, out3 intact
        rd(18, 5, "R6_R3");  // caller local2 back, global5
        rd(12, 26, "R11");
        // R8: restore at base
        step(1'b0, 0, 32'h0, 0, 0, 1'b0, 1'b1, "R8");
        rd(0, 0, "R8");
        // R9: simultaneous strobes
        step(1'b0, 0, 32'h0, 0, 0, 1'b1, 1'b1, "R9");
        // R7: fill to depth 6, then one more save
        for (int i = 0; i < 6; i++) step(1'b1, 8 + i, 32'hF000_0000 + i, 24, 8, 1'b1, 1'b0, "R4");
        step(1'b0, 0, 32'h0, 0, 0, 1'b1, 1'b0, "R7");
        rd(24, 29, "R7");
        step(1'b0, 0, 32'h0, 0, 0, 1'b1, 1'b1, "R9");
        for (int i = 0; i < 6; i++) step(1'b0, 0, 32'h0, 8 + i, 24, 1'b0, 1'b1, "R5");
        // Pseudo-random traffic compared with the model every clock
        for (int i = 0; i < 4000; i++) begin
            int c;
            c = int'($urandom_range(0, 9));
            step(($urandom_range(0, 2) != 0), int'($urandom_range(0, 31)), $urandom,
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                 (c == 0 || c == 1 || c == 9), (c == 2 || c == 3 || c == 9), "R4_R5_random");
        end
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule